// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This unit takes one IEEE-754 single-precision operand and returns a coarse estimate of its reciprocal square root. A later Newton-Raphson sequence refines that estimate. Normal positive operands are handled in two parts. The result exponent comes from a fixed subtraction on the operand exponent. Eight result mantissa bits are read from a 128-entry seed table, which is supplied as a parameter. The remaining low mantissa bits of the result are zero.

Operands that are not normal and positive are resolved by a fixed classification order:

1. NaN
2. Zero or denormal
3. Negative
4. Positive infinity
5. Normal

An invalid-operation flag and a summary flag go out with each result.

The result is registered. It appears one clock after an input strobe, together with an output strobe, and it holds while no new operand arrives.

Top module: `rsq_seed`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `outResult`, `outInvalid` and `outSummary` are all zero until the first accepted operand.
- R2: Each cycle with `inValid` high gives `outValid` high in the following cycle. A cycle without `inValid` gives `outValid` low in the following cycle, with `outResult` and both flags unchanged.
- R3: An operand with exponent field (bits 30:23) all ones and a nonzero mantissa (bits 22:0) gives 0x7FC00000, whatever its sign and payload.
- R4: A non-NaN operand whose exponent field is zero (a signed zero or a denormal) gives infinity with the operand's sign: 0x7F800000 or 0xFF800000. This takes priority over the negative case.
- R5: A negative operand that is neither NaN nor zero/denormal gives 0x7FC00004. This includes negative infinity.
- R6: Positive infinity (0x7F800000) gives 0x00000000.
- R7: For a positive normal operand with exponent field E, the result's sign is 0. Its exponent field is 0xBD − ((E−1) >> 1), and its bits 14:0 are zero.
- R8: For a positive normal operand, result bits 22:15 equal table entry number {(E−1) bit 0, operand bits 22:17}. The exponent-parity bit is the most significant bit of the 7-bit index.
- R9: `outInvalid` and `outSummary` are both 1 for a signalling NaN (exponent all ones, nonzero mantissa, bit 22 = 0) and for any R5 result. For every other operand, including quiet NaNs, both are 0.
- R10: Operands strobed on consecutive cycles each produce their own result, in order, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| inOperand | input | 32 | Single-precision operand |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outResult | output | 32 | Seed or special-case result |
| outInvalid | output | 1 | Invalid-operation flag for this result |
| outSummary | output | 1 | Summary flag for this result |

## Verification
Two classification rules can match the same operand. A negative denormal or negative zero is both negative and zero-exponent. A signalling NaN both selects the NaN result and raises the invalid flag. Negative infinity is both negative and infinite. The bench sends each of these operands and expects the result chosen by the fixed priority. It also expects the flag state that belongs to that winning case. The bench supplies its own seed table, so a wrong index bit order or a wrong exponent parity shows up directly in result bits 22:15.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int FW         = 32;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = 23;
  localparam int SEED_W     = 8;
  localparam int IDX_MBITS  = 6;
  localparam int IDX_W      = IDX_MBITS + 1;
  localparam int TBL_DEPTH  = 1 << IDX_W;
  localparam int LOW_ZERO_W = MAN_W - SEED_W;
  localparam int SCALE_LOG2 = 2 * SEED_W + IDX_MBITS + 3;

  localparam logic [EXP_W-1:0] EXP_BASE = 8'hBD;
  localparam logic [FW-1:0] QNAN_WORD   = 32'h7FC0_0000;
  localparam logic [FW-1:0] ROOT_NAN    = 32'h7FC0_0004;

  typedef logic [SEED_W-1:0] seedTable_t [TBL_DEPTH];

  // One-hot class strobes from control to datapath, plus the flag strobe.
  typedef struct packed {
    logic selNan;
    logic selZero;
    logic selNeg;
    logic selInf;
    logic selNorm;
    logic raiseInv;
  } rsqSel_t;

  function automatic int unsigned isqrtU(input int unsigned v);
    int unsigned r;
    int unsigned c;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      c = r | (32'd1 << b);
      if (c * c <= v) r = c;
    end
    return r;
  endfunction

  // Midpoint estimate of 1/sqrt(x) for each bucket, scaled to the mantissa field.
  function automatic seedTable_t defaultSeedTable();
    seedTable_t t;
    int unsigned s;
    int unsigned r;
    for (int i = 0; i < TBL_DEPTH; i++) begin
      s = (32'(2 * (i % (1 << IDX_MBITS))) + (32'd1 << (IDX_MBITS + 1)) + 32'd1)
          << (i >> IDX_MBITS);
      r = isqrtU((32'd1 << SCALE_LOG2) / s);
      if (r >= (32'd2 << SEED_W))      t[i] = '1;
      else if (r < (32'd1 << SEED_W))  t[i] = '0;
      else                             t[i] = SEED_W'(r - (32'd1 << SEED_W));
    end
    return t;
  endfunction
endpackage

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
(
  input  logic          inValid,
  input  logic [FW-1:0] inOperand,
  output rsqSel_t       sel,
  output logic          loadEn
);
  logic             opSign;
  logic [EXP_W-1:0] opExp;
  logic [MAN_W-1:0] opMan;
  logic             expFull;
  logic             expNone;
  logic             manNone;

  assign opSign  = inOperand[FW-1];
  assign opExp   = inOperand[FW-2 -: EXP_W];
  assign opMan   = inOperand[MAN_W-1:0];
  assign expFull = &opExp;
  assign expNone = ~|opExp;
  assign manNone = ~|opMan;

  // Priority: NaN, zero/denormal, negative, infinity, normal.
  always_comb begin
    sel = '0;
    if (expFull && !manNone) begin
      sel.selNan   = 1'b1;
      sel.raiseInv = !opMan[MAN_W-1];
    end else if (expNone) begin
      sel.selZero = 1'b1;
    end else if (opSign) begin
      sel.selNeg   = 1'b1;
      sel.raiseInv = 1'b1;
    end else if (expFull) begin
      sel.selInf = 1'b1;
    end else begin
      sel.selNorm = 1'b1;
    end
  end

  assign loadEn = inValid;
endmodule

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter seedTable_t SEED_TABLE = defaultSeedTable()
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opSign,
  input  logic [EXP_W-1:0]     opExp,
  input  logic [IDX_MBITS-1:0] opManTop,
  input  rsqSel_t              sel,
  input  logic                 loadEn,
  output logic                 outValid,
  output logic [FW-1:0]        outResult,
  output logic                 outInvalid,
  output logic                 outSummary
);
  logic [EXP_W-1:0]  expLess1;
  logic [EXP_W-1:0]  seedExp;
  logic [IDX_W-1:0]  tblIdx;
  logic [SEED_W-1:0] seedMan;
  logic [FW-1:0]     nextResult;

  assign expLess1 = opExp - EXP_W'(1);
  assign tblIdx   = {expLess1[0], opManTop};
  assign seedMan  = SEED_TABLE[tblIdx];
  assign seedExp  = EXP_BASE - (expLess1 >> 1);

  always_comb begin
    if (sel.selNan)       nextResult = QNAN_WORD;
    else if (sel.selZero) nextResult = {opSign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (sel.selNeg)  nextResult = ROOT_NAN;
    else if (sel.selInf)  nextResult = '0;
    else if (sel.selNorm) nextResult = {opSign, seedExp, seedMan, {LOW_ZERO_W{1'b0}}};
    else                  nextResult = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outResult  <= '0;
      outInvalid <= 1'b0;
      outSummary <= 1'b0;
    end else begin
      outValid <= loadEn;
      if (loadEn) begin
        outResult  <= nextResult;
        outInvalid <= sel.raiseInv;
        outSummary <= sel.raiseInv;
      end
    end
  end
endmodule

// File: rtl/rsq_seed.sv
module rsq_seed
  import rsq_pkg::*;
#(
  parameter seedTable_t SEED_TABLE = defaultSeedTable()
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [FW-1:0] inOperand,
  output logic          outValid,
  output logic [FW-1:0] outResult,
  output logic          outInvalid,
  output logic          outSummary
);
  rsqSel_t sel;
  logic    loadEn;

  rsq_ctrl u_ctrl (
    .inValid  (inValid),
    .inOperand(inOperand),
    .sel      (sel),
    .loadEn   (loadEn)
  );

  rsq_datapath #(.SEED_TABLE(SEED_TABLE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opSign    (inOperand[FW-1]),
    .opExp     (inOperand[FW-2 -: EXP_W]),
    .opManTop  (inOperand[MAN_W-1 -: IDX_MBITS]),
    .sel       (sel),
    .loadEn    (loadEn),
    .outValid  (outValid),
    .outResult (outResult),
    .outInvalid(outInvalid),
    .outSummary(outSummary)
  );
endmodule

// File: rtl/rsq_seed_chk.sv
module rsq_seed_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inOperand,
  input logic        outValid,
  input logic [31:0] outResult,
  input logic        outInvalid,
  input logic        outSummary
);
  logic isNanIn;
  logic isSnanIn;
  logic isPosNormIn;
  assign isNanIn     = (&inOperand[30:23]) && (|inOperand[22:0]);
  assign isSnanIn    = isNanIn && !inOperand[22];
  assign isPosNormIn = !inOperand[31] && (|inOperand[30:23]) && !(&inOperand[30:23]);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outResult) && $stable(outSummary)); // R2
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isNanIn |=> outResult == 32'h7FC0_0000); // R3
  AST_POS_INF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOperand == 32'h7F80_0000 |=> outResult == 32'h0); // R6
  AST_NORM_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isPosNormIn |=> outResult[14:0] == 15'h0 && !outResult[31]); // R7
  AST_SNAN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isSnanIn |=> outInvalid && outSummary); // R9
  AST_ROOT_NAN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outResult == 32'h7FC0_0004 |-> outInvalid); // R5
  AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inOperand[31] && !isNanIn |=> !outInvalid && !outSummary); // R9
endmodule

bind rsq_seed rsq_seed_chk u_chk (.*);

// File: tb/rsq_seed_tb.sv
`timescale 1ns/1ps
module rsq_seed_tb;
  import rsq_pkg::*;

  function automatic seedTable_t benchTable();
    seedTable_t t;
    for (int i = 0; i < TBL_DEPTH; i++) t[i] = SEED_W'((i * 53 + 17) ^ (i << 3));
    return t;
  endfunction
  localparam seedTable_t TB_TABLE = benchTable();

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inOperand = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic        outInvalid;
  logic        outSummary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [32:0] expQ[$];
  string       tagQ[$];
  logic [32:0] lastExp = '0;

  always #10 clk = ~clk;

  rsq_seed #(.SEED_TABLE(TB_TABLE)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .outValid(outValid), .outResult(outResult),
    .outInvalid(outInvalid), .outSummary(outSummary)
  );

  function automatic logic [32:0] expectFor(input logic [31:0] x, output string tag);
    logic [7:0]  e;
    logic [22:0] m;
    logic [7:0]  em;
    e = x[30:23];
    m = x[22:0];
    if (e == 8'hFF && m != 0) begin
      tag = m[22] ? "R3" : "R9";
      return {32'h7FC0_0000, !m[22]};
    end else if (e == 8'h00) begin
      tag = "R4";
      return {x[31], 8'hFF, 23'h0, 1'b0};
    end else if (x[31]) begin
      tag = "R5";
      return {32'h7FC0_0004, 1'b1};
    end else if (e == 8'hFF) begin
      tag = "R6";
      return {32'h0, 1'b0};
    end
    tag = "R7_R8";
    em = e - 8'd1;
    return {1'b0, 8'(8'hBD - (em >> 1)), TB_TABLE[{em[0], m[22:17]}], 15'h0, 1'b0};
  endfunction

  task automatic drive(input logic [31:0] x);
    string t;
    logic [32:0] ex;
    ex = expectFor(x, t);
    expQ.push_back(ex);
    tagQ.push_back(t);
    lastExp = ex;
    inValid = 1'b1;
    inOperand = x;
    @(negedge clk);
  endtask

  // Idle cycle: output must hold the last result with the strobe low (R2).
  task automatic idleCheck();
    inValid = 1'b0;
    inOperand = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || {outResult, outInvalid} !== lastExp || outSummary !== lastExp[0]) begin
      errors++;
      $display("FAIL R2 hold: act v=%b r=%h f=%b exp v=0 r=%h f=%b",
               outValid, outResult, outInvalid, lastExp[32:1], lastExp[0]);
    end
  endtask

  // Monitor: scoreboard compare of every produced result (R10 ordering).
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result: act %h exp none", outResult);
      end else begin
        logic [32:0] ex;
        string t;
        ex = expQ.pop_front();
        t = tagQ.pop_front();
        if ({outResult, outInvalid} !== ex || outSummary !== ex[0]) begin
          errors++;
          $display("FAIL %s: act r=%h inv=%b sum=%b exp r=%h flags=%b",
                   t, outResult, outInvalid, outSummary, ex[32:1], ex[0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checks++; // R1 during reset
    if ({outValid, outResult, outInvalid, outSummary} !== '0) begin
      errors++;
      $display("FAIL R1 in reset: act %b %h %b %b exp all zero", outValid, outResult, outInvalid, outSummary);
    end
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++; // R1 after release
    if ({outValid, outResult, outInvalid, outSummary} !== '0) begin
      errors++;
      $display("FAIL R1 after reset: act %b %h %b %b exp all zero", outValid, outResult, outInvalid, outSummary);
    end

    // Special cases, back to back (R3..R6, R9, R10)
    drive(32'h7FC1_2345);
    drive(32'hFFC0_0000);
    drive(32'h7F80_0001);
    drive(32'hFFA0_0000);
    drive(32'h0000_0000);
    drive(32'h8000_0000);
    drive(32'h0000_0001);
    drive(32'h8040_0000);
    drive(32'hFF80_0000);
    drive(32'hBF80_0000);
    drive(32'h7F80_0000);
    idleCheck();
    // Normal range boundaries (R7, R8)
    drive(32'h3F80_0000);
    drive(32'h4000_0000);
    drive(32'h0080_0000);
    drive(32'h7F7F_FFFF);
    idleCheck();
    // Exponent parity and index sweep (R7, R8, R10)
    foreach (TB_TABLE[k]) begin
      if (k < 8) begin
        logic [7:0] ev;
        case (k)
          0: ev = 8'd1;   1: ev = 8'd2;   2: ev = 8'd126; 3: ev = 8'd127;
          4: ev = 8'd128; 5: ev = 8'd200; 6: ev = 8'd253; default: ev = 8'd254;
        endcase
        for (int j = 0; j < 6; j++) begin
          logic [5:0] mt;
          case (j)
            0: mt = 6'd0;  1: mt = 6'd1;  2: mt = 6'd31;
            3: mt = 6'd32; 4: mt = 6'd62; default: mt = 6'd63;
          endcase
          drive({1'b0, ev, mt, 17'h15A5A});
        end
      end
    end
    idleCheck();
    drive(32'h7FBF_FFFF);
    idleCheck();

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 results missing: act %0d pending exp 0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule